// File: doc/BRIEF.md
# Privilege-Aware Segment Address Decoder

This block takes a virtual address, together with the privilege mode, the error-level status bit and the access type of the access that issued it. It places the address in one of five fixed segments by its top three bits. It then decides whether the access is translated directly to a physical address, is handed on to an external translation lookaside buffer (TLB), or is refused as an address error.

The decode itself is combinational. The result is held in a single output register, with a valid/ready handshake on the request side and on the response side. Accepted requests therefore come out one cycle later, and a held response stalls new requests until it is taken.

Directly translated segments give read and write permission. For mapped segments the permission bits stay low, because they belong to the TLB. While the error-level bit is set, the low user segment becomes an identity window with read and write permission.

Top module: `vseg_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An address below 0x80000000 with `req_erl`=0 is mapped from every mode: `rsp_mapped`=1, `rsp_addr_err`=0, `rsp_paddr`=0, `rsp_rd_ok`=`rsp_wr_ok`=0, `tlb_req_valid`=1 and `tlb_vaddr` equal to the request address.
- R3: An address below 0x80000000 with `req_erl`=1 is unmapped in every mode: `rsp_paddr` equals the virtual address, and `rsp_rd_ok`=`rsp_wr_ok`=1.
- R4: An address in 0x80000000..0x9FFFFFFF from kernel mode (`req_mode` 2 or 3) is unmapped, with `rsp_paddr` = address − 0x80000000 and read and write permitted.
- R5: An address in 0xA0000000..0xBFFFFFFF from kernel mode is unmapped, with `rsp_paddr` = address − 0xA0000000 and read and write permitted.
- R6: An address in 0xC0000000..0xDFFFFFFF is mapped from supervisor (`req_mode`=1) or kernel mode, and is an address error from user mode (`req_mode`=0).
- R7: An address at or above 0xE0000000 is mapped from kernel mode only, and is an address error from user or supervisor mode.
- R8: An address in 0x80000000..0xBFFFFFFF from user or supervisor mode is an address error.
- R9: On an address error, `rsp_addr_err`=1, `rsp_mapped`=0, `rsp_paddr`=0, both permission bits are 0 and `tlb_req_valid`=0. `rsp_acc` carries the access type (0 fetch, 1 load, 2 store), so a store can be told apart.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. Its response is valid from the next cycle and is held unchanged while `rsp_ready` is low. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R11: A new request can be accepted in the same cycle in which the previous response is taken, so responses flow with no gap.
- R12: The error-level bit has no effect on addresses at or above 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | AW | Virtual address |
| req_mode | input | 2 | 0 user, 1 supervisor, 2 or 3 kernel |
| req_erl | input | 1 | Error-level status bit |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_mapped | output | 1 | Address goes through the TLB |
| rsp_paddr | output | AW | Direct physical address (0 when mapped or on error) |
| rsp_rd_ok | output | 1 | Read permitted by direct translation |
| rsp_wr_ok | output | 1 | Write permitted by direct translation |
| rsp_addr_err | output | 1 | Bad-address result |
| rsp_acc | output | 2 | Access type of the response |
| tlb_req_valid | output | 1 | Translation request to the TLB |
| tlb_vaddr | output | AW | Address handed to the TLB |
| tlb_acc | output | 2 | Access type handed to the TLB |

## Verification
The functions that meet in one cycle are the draining of a held response and the acceptance of the next request. When `rsp_ready` is high while a response is valid, a new request enters in the same edge and replaces the old one. The bench provokes this with long runs of back-to-back requests under a randomly toggled `rsp_ready`. A reference queue tracks each accepted request and pops on each handshake, and the bench compares every field with its front entry on every clock. Any lost, duplicated or early response therefore shows up as a mismatch with the queue occupancy.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [2:0] {
        SEG_USER   = 3'd0,
        SEG_KDIR0  = 3'd1,
        SEG_KDIR1  = 3'd2,
        SEG_SUPMAP = 3'd3,
        SEG_KERMAP = 3'd4
    } seg_e;

    localparam logic [1:0] MODE_USER  = 2'd0;
    localparam logic [1:0] MODE_SUPER = 2'd1;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
    import vseg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    output seg_e          seg
);
    localparam int TOP = 3;

    logic [TOP-1:0] top_bits;

    always_comb begin
        top_bits = vaddr[AW-1 -: TOP];
        if (!top_bits[TOP-1]) begin
            seg = SEG_USER;
        end else begin
            unique case (top_bits[TOP-2:0])
                2'b00:   seg = SEG_KDIR0;
                2'b01:   seg = SEG_KDIR1;
                2'b10:   seg = SEG_SUPMAP;
                default: seg = SEG_KERMAP;
            endcase
        end
    end
endmodule

// File: rtl/vseg_permit.sv
module vseg_permit
    import vseg_pkg::*;
#(
    parameter int AW = 32
) (
    input  seg_e          seg,
    input  logic [AW-1:0] vaddr,
    input  logic [1:0]    mode,
    input  logic          erl,
    output logic          mapped,
    output logic          bad,
    output logic          rd_ok,
    output logic          wr_ok,
    output logic [AW-1:0] paddr
);
    localparam int OFS_W = AW - 3;

    logic is_user;
    logic is_super;
    logic is_kernel;
    logic direct;
    logic [AW-1:0] window;

    always_comb begin
        is_user   = (mode == MODE_USER);
        is_super  = (mode == MODE_SUPER);
        is_kernel = !is_user && !is_super;
        window    = {3'b000, vaddr[OFS_W-1:0]};

        mapped = 1'b0;
        bad    = 1'b0;
        direct = 1'b0;
        paddr  = '0;
        unique case (seg)
            SEG_USER: begin
                if (erl) begin
                    direct = 1'b1;
                    paddr  = vaddr;
                end else begin
                    mapped = 1'b1;
                end
            end
            SEG_KDIR0, SEG_KDIR1: begin
                if (is_kernel) begin
                    direct = 1'b1;
                    paddr  = window;
                end else begin
                    bad = 1'b1;
                end
            end
            SEG_SUPMAP: begin
                mapped = !is_user;
                bad    = is_user;
            end
            default: begin
                mapped = is_kernel;
                bad    = !is_kernel;
            end
        endcase
        rd_ok = direct;
        wr_ok = direct;
    end
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
    import vseg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [1:0]    req_mode,
    input  logic          req_erl,
    input  logic [1:0]    req_acc,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic          rsp_mapped,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_rd_ok,
    output logic          rsp_wr_ok,
    output logic          rsp_addr_err,
    output logic [1:0]    rsp_acc,
    output logic          tlb_req_valid,
    output logic [AW-1:0] tlb_vaddr,
    output logic [1:0]    tlb_acc
);
    typedef struct packed {
        logic          valid;
        logic          mapped;
        logic          bad;
        logic          rd_ok;
        logic          wr_ok;
        logic [AW-1:0] paddr;
        logic [AW-1:0] vaddr;
        logic [1:0]    acc;
    } slot_t;

    slot_t st_d, st_q;

    seg_e          seg_w;
    logic          mapped_w, bad_w, rd_w, wr_w;
    logic [AW-1:0] paddr_w;
    logic          take_w;

    vseg_classify #(.AW(AW)) u_classify (
        .vaddr (req_vaddr),
        .seg   (seg_w)
    );

    vseg_permit #(.AW(AW)) u_permit (
        .seg    (seg_w),
        .vaddr  (req_vaddr),
        .mode   (req_mode),
        .erl    (req_erl),
        .mapped (mapped_w),
        .bad    (bad_w),
        .rd_ok  (rd_w),
        .wr_ok  (wr_w),
        .paddr  (paddr_w)
    );

    always_comb begin
        req_ready = !st_q.valid || rsp_ready;
        take_w    = req_valid && req_ready;
        st_d      = st_q;
        if (take_w) begin
            st_d.valid  = 1'b1;
            st_d.mapped = mapped_w;
            st_d.bad    = bad_w;
            st_d.rd_ok  = rd_w;
            st_d.wr_ok  = wr_w;
            st_d.paddr  = paddr_w;
            st_d.vaddr  = req_vaddr;
            st_d.acc    = req_acc;
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.valid;
    assign rsp_mapped    = st_q.mapped;
    assign rsp_paddr     = st_q.paddr;
    assign rsp_rd_ok     = st_q.rd_ok;
    assign rsp_wr_ok     = st_q.wr_ok;
    assign rsp_addr_err  = st_q.bad;
    assign rsp_acc       = st_q.acc;
    assign tlb_req_valid = st_q.valid && st_q.mapped;
    assign tlb_vaddr     = st_q.vaddr;
    assign tlb_acc       = st_q.acc;
endmodule

// File: rtl/vseg_decoder_chk.sv
module vseg_decoder_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic [1:0]    req_mode,
    input logic          req_erl,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic          rsp_mapped,
    input logic [AW-1:0] rsp_paddr,
    input logic          rsp_rd_ok,
    input logic          rsp_addr_err,
    input logic          tlb_req_valid,
    input logic [AW-1:0] tlb_vaddr
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_addr_err) && $stable(rsp_mapped));

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_addr_err |-> !rsp_mapped && !tlb_req_valid && !rsp_rd_ok
            && rsp_paddr == '0);

    assert_user_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mode == 2'd0 && req_vaddr[AW-1]
            |=> rsp_valid && rsp_addr_err);

    assert_erl_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_erl && !req_vaddr[AW-1]
            |=> rsp_valid && !rsp_mapped && rsp_paddr == $past(req_vaddr));

    assert_kdirect_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |-> tlb_vaddr[AW-1 -: 2] != 2'b10);

    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);
endmodule

bind vseg_decoder vseg_decoder_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_mode      (req_mode),
    .req_erl       (req_erl),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_mapped    (rsp_mapped),
    .rsp_paddr     (rsp_paddr),
    .rsp_rd_ok     (rsp_rd_ok),
    .rsp_addr_err  (rsp_addr_err),
    .tlb_req_valid (tlb_req_valid),
    .tlb_vaddr     (tlb_vaddr)
);

// File: tb/vseg_decoder_bench.sv
module vseg_decoder_bench;
    localparam int W = 71;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        req_erl = 1'b0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_mapped;
    logic [31:0] rsp_paddr;
    logic        rsp_rd_ok, rsp_wr_ok, rsp_addr_err;
    logic [1:0]  rsp_acc;
    logic        tlb_req_valid;
    logic [31:0] tlb_vaddr;
    logic [1:0]  tlb_acc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #10 clk = ~clk;

    vseg_decoder u_vseg_decoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .req_erl(req_erl), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_mapped(rsp_mapped),
        .rsp_paddr(rsp_paddr), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
        .rsp_addr_err(rsp_addr_err), .rsp_acc(rsp_acc),
        .tlb_req_valid(tlb_req_valid), .tlb_vaddr(tlb_vaddr), .tlb_acc(tlb_acc)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [31:0] a, input logic [1:0] m,
                                           input logic e, input logic [1:0] c,
                                           output string tag);
        bit user, kern, map, err, dir;
        logic [31:0] pa;
        user = (m == 0);
        kern = (m >= 2);
        map = 0; err = 0; dir = 0; pa = 0;
        if (a < 32'h8000_0000) begin
            if (e) begin dir = 1; pa = a; tag = "R3"; end
            else begin map = 1; tag = "R2"; end
        end else if (a < 32'hA000_0000) begin
            if (kern) begin dir = 1; pa = a - 32'h8000_0000; tag = "R4"; end
            else begin err = 1; tag = "R8 R9"; end
        end else if (a < 32'hC000_0000) begin
            if (kern) begin dir = 1; pa = a - 32'hA000_0000; tag = "R5"; end
            else begin err = 1; tag = "R8 R9"; end
        end else if (a < 32'hE000_0000) begin
            if (!user) map = 1; else err = 1;
            tag = err ? "R6 R9" : "R6";
        end else begin
            if (kern) map = 1; else err = 1;
            tag = err ? "R7 R9" : "R7";
        end
        if (e && a >= 32'h8000_0000) tag = {tag, " R12"};
        return {map, err, dir, dir, pa, c, map, map ? a : 32'h0};
    endfunction

    task automatic compare();
        logic [W-1:0] act;
        check(rsp_valid === (exp_q.size() != 0), "R10 R11 rsp_valid",
              W'(rsp_valid), W'(exp_q.size() != 0));
        if (rsp_valid && exp_q.size() != 0) begin
            act = {rsp_mapped, rsp_addr_err, rsp_rd_ok, rsp_wr_ok, rsp_paddr, rsp_acc,
                   tlb_req_valid, tlb_req_valid ? tlb_vaddr : 32'h0};
            check(act === exp_q[0] && (!tlb_req_valid || tlb_acc === rsp_acc),
                  tag_q[0], act, exp_q[0]);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] m,
                        input logic e, input logic [1:0] c, input logic r);
        string t;
        logic [W-1:0] x;
        @(negedge clk);
        compare();
        req_valid = v; req_vaddr = a; req_mode = m; req_erl = e; req_acc = c;
        rsp_ready = r;
        #1;
        check(req_ready === (!rsp_valid || rsp_ready), "R10 req_ready",
              W'(req_ready), W'(!rsp_valid || rsp_ready));
        if (rsp_valid && rsp_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        if (req_valid && req_ready) begin
            x = model(a, m, e, c, t);
            exp_q.push_back(x);
            tag_q.push_back(t);
        end
    endtask

    function automatic logic [31:0] pick_addr();
        logic [31:0] base;
        base = {$urandom_range(7, 0), 29'h0};
        case ($urandom_range(3, 0))
            0: return base;
            1: return base | 32'h1FFF_FFFF;
            default: return base | ($urandom() & 32'h1FFF_FFFF);
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 reset",
              W'({rsp_valid, req_ready}), W'(2'b01));

        // directed: one segment per step, back-to-back with ready high (R11)
        for (int m = 0; m < 4; m++) begin
            step(1, 32'h0000_0000, 2'(m), 0, 1, 1);   // R2
            step(1, 32'h7FFF_FFFF, 2'(m), 1, 0, 1);   // R3
            step(1, 32'h8000_0000, 2'(m), 0, 2, 1);   // R4 / R8
            step(1, 32'h9FFF_FFFC, 2'(m), 1, 1, 1);   // R4 / R12
            step(1, 32'hA000_0010, 2'(m), 0, 2, 1);   // R5 / R9 store
            step(1, 32'hBFFF_FFFF, 2'(m), 1, 0, 1);   // R5
            step(1, 32'hC000_0000, 2'(m), 0, 1, 1);   // R6
            step(1, 32'hDFFF_FFFF, 2'(m), 1, 2, 1);   // R6
            step(1, 32'hE000_0000, 2'(m), 0, 0, 1);   // R7
            step(1, 32'hFFFF_FFFF, 2'(m), 1, 2, 1);   // R7 / R12
        end
        // backpressure: response held, new request stalled (R10)
        step(1, 32'h1234_5678, 0, 0, 1, 0);
        step(1, 32'hC000_1000, 0, 0, 2, 0);
        step(1, 32'hC000_1000, 0, 0, 2, 0);
        step(1, 32'hC000_1000, 0, 0, 2, 1);
        step(0, 32'h0, 0, 0, 0, 1);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            step(1'($urandom_range(3, 0) != 0), pick_addr(), 2'($urandom_range(3, 0)),
                 1'($urandom_range(1, 0)), 2'($urandom_range(2, 0)),
                 1'($urandom_range(3, 0) != 0));
        end
        step(0, 32'h0, 0, 0, 0, 1);
        step(0, 32'h0, 0, 0, 0, 1);
        @(negedge clk);
        compare();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule